// File: doc/BRIEF.md
# Multi-endpoint transmit FIFO bank

This block holds the outgoing data for up to four IN endpoints. Each endpoint has its own word-wide FIFO, and its depth is set by a parameter. A depth of zero removes the storage for an endpoint that is not used. Software loads data one 32-bit word at a time through a single write port that carries an endpoint number. A packet engine on the other side selects an endpoint and pulls words out in arrival order.

For each endpoint the block reports a live count of free word slots, which lets software write exactly as many words as will fit. Each endpoint also has a transmit-empty interrupt that calls for a refill. One global mode input moves every endpoint's interrupt threshold at once. In one mode the interrupt fires when the FIFO holds nothing. In the other it fires as soon as at least half the slots are free, which gives software time to refill before the engine runs dry.

Top module: `txfifo_bank`

## Requirements
- R1: After a synchronous active-low reset every FIFO is empty. Its free count equals its depth, its overflow flag is 0, and `rd_valid` is 0 for every endpoint.
- R2: An accepted write adds one word to the FIFO that `wr_ep` addresses. The free count (`stat_free` for `stat_ep`) drops by one, and the new count is visible after the clock edge that takes the write.
- R3: A write to a full FIFO is dropped and its stored words stay as they were. The endpoint's sticky `ovf` bit is set and stays 1 until that endpoint is flushed.
- R4: While the FIFO that `rd_ep` selects holds data, `rd_valid` is 1 and `rd_data` shows its oldest word. A read strobe removes that word, so words leave in the order they were written.
- R5: A read strobe on an empty FIFO has no effect: `rd_valid` is 0 and the free count does not change.
- R6: A write and a read on the same endpoint in the same cycle, with the FIFO neither empty nor full, leave its occupancy unchanged. The written word is kept behind the older ones.
- R7: A 1 on bit i of `flush` empties FIFO i in one cycle and clears its `ovf` bit. No other endpoint changes.
- R8: With `half_mode` = 0, `irq[i]` is 1 exactly when endpoint i has storage, holds no words and `irq_en[i]` is 1.
- R9: With `half_mode` = 1, `irq[i]` is 1 exactly when endpoint i has storage, twice its free count is at least its depth, and `irq_en[i]` is 1.
- R10: `irq[i]` is 0 whenever `irq_en[i]` is 0, whatever the fill level.
- R11: An endpoint of depth 0 always reports a free count of 0, never raises `irq` and never shows `rd_valid`. A write to it is dropped and sets its `ovf` bit.
- R12: Writes, reads and flushes on one endpoint never change the free count or the data of any other endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_mode | input | 1 | Global interrupt threshold: 1 = half empty, 0 = fully empty |
| irq_en | input | 4 | Per-endpoint interrupt enable |
| flush | input | 4 | Per-endpoint flush, empties that FIFO |
| wr_en | input | 1 | Word write strobe |
| wr_ep | input | 2 | Endpoint addressed by the write |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Read strobe from the packet engine |
| rd_ep | input | 2 | Endpoint selected for draining |
| rd_data | output | 32 | Oldest word of the selected FIFO |
| rd_valid | output | 1 | Selected FIFO holds a word |
| stat_ep | input | 2 | Endpoint selected for the status read |
| stat_free | output | CW | Free word slots of the selected FIFO (CW = 8 with the default depths) |
| irq | output | 4 | Per-endpoint transmit-empty interrupt |
| ovf | output | 4 | Per-endpoint sticky overflow flag |

## Verification
Assertions inside each endpoint FIFO check the following on every cycle:
- the occupancy never exceeds the depth;
- an accepted write alone adds exactly one word;
- a dropped write or an empty read leaves the occupancy alone;
- a flush empties the FIFO on the next cycle;
- an interrupt never appears while its enable is 0;
- a zero-depth endpoint stays silent.

Word ordering, the exact free count under both threshold modes, the stickiness of overflow and the isolation between endpoints can only be shown by the bench. It sweeps every endpoint of a small configuration with depths 4, 5, 0 and 2 through full, over-full, drained and flushed states, checks the results against an arithmetic model, and sweeps every interrupt enable pattern.

// File: rtl/txfb_pkg.sv
// Package: txfb_pkg
// Width helpers shared by the transmit FIFO bank. Assumes depths are
// small enough that their counts fit in 32-bit ints.
package txfb_pkg;

    // Interrupt threshold selection, decoded from the global mode bit.
    typedef enum logic {
        THR_EMPTY = 1'b0,
        THR_HALF  = 1'b1
    } thr_mode_e;

    // Bits needed to hold a count of 0..n, never fewer than one.
    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

    // Bits needed to index 0..depth-1, never fewer than one.
    function automatic int unsigned ptr_width(input int unsigned depth);
        return (depth <= 2) ? 1 : cnt_width(depth - 1);
    endfunction

endpackage

// File: rtl/ep_fifo.sv
// Module: ep_fifo
// One endpoint's transmit FIFO. It holds the storage, the occupancy count,
// the free-space count, the sticky overflow bit and the transmit-empty
// interrupt. The head word is presented combinationally (show-ahead).
// Assumes push_req and pop_req are already decoded for this endpoint.
// DEPTH = 0 builds no storage: the FIFO reports itself full, silent and empty.
module ep_fifo
    import txfb_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned DW    = 32,
    parameter int unsigned CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_mode,
    input  logic          irq_en,
    input  logic          flush,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [DW-1:0] push_data,
    output logic [DW-1:0] head_data,
    output logic          head_valid,
    output logic [CW-1:0] free_cnt,
    output logic          irq,
    output logic          ovf
);

    if (DEPTH == 0) begin : g_none
        logic ovf_q;

        // Every write to an endpoint without storage is an overflow.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) ovf_q <= 1'b0;
            else if (push_req)   ovf_q <= 1'b1;
        end

        assign head_data  = '0;
        assign head_valid = 1'b0;
        assign free_cnt   = '0;
        assign irq        = 1'b0;
        assign ovf        = ovf_q;

        // R11: a zero-depth endpoint never interrupts and never offers data
        always_comb begin
            p_silent_r11: assert (!irq && !head_valid && free_cnt == '0);
        end

    end else begin : g_store
        localparam int unsigned PW = ptr_width(DEPTH);
        localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
        localparam logic [CW-1:0] FULL = CW'(DEPTH);

        logic [DW-1:0] mem [DEPTH];
        logic [PW-1:0] wr_ptr, rd_ptr;
        logic [CW-1:0] cnt;
        logic          ovf_q;
        logic          full, empty, push, pop;
        thr_mode_e     thr;

        assign full  = (cnt == FULL);
        assign empty = (cnt == '0);
        assign push  = push_req && !full && !flush;
        assign pop   = pop_req && !empty && !flush;
        assign thr   = thr_mode_e'(half_mode);

        // Store an accepted word at the write pointer.
        always_ff @(posedge clk) begin
            if (push) mem[wr_ptr] <= push_data;
        end

        // Advance the pointers and the occupancy; flush returns them to empty.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                cnt    <= '0;
            end else begin
                if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
                if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
                if (push && !pop)      cnt <= cnt + 1'b1;
                else if (pop && !push) cnt <= cnt - 1'b1;
            end
        end

        // Latch a write that arrived while full until the next flush.
        always_ff @(posedge clk) begin
            if (!rst_n || flush)          ovf_q <= 1'b0;
            else if (push_req && full)    ovf_q <= 1'b1;
        end

        // Compare the fill level with the threshold the mode selects.
        always_comb begin
            if (thr == THR_HALF) irq = irq_en && ({1'b0, free_cnt, 1'b0} >= (CW+2)'(DEPTH));
            else                 irq = irq_en && empty;
        end

        assign free_cnt   = FULL - cnt;
        assign head_data  = mem[rd_ptr];
        assign head_valid = !empty;
        assign ovf        = ovf_q;

        // R2: occupancy stays inside the storage
        p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= FULL);
        // R2: a lone accepted write adds exactly one word
        p_push_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (push_req && !full && !pop_req && !flush) |=> cnt == $past(cnt) + 1'b1);
        // R3: a write to a full FIFO leaves it full and flags overflow
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (push_req && full && !pop_req && !flush) |=> (cnt == FULL && ovf));
        // R5: reading an empty FIFO changes nothing
        p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_req && empty && !push_req && !flush) |=> cnt == '0);
        // R6: a write and a read together keep the occupancy
        p_pass_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (push_req && pop_req && !empty && !full && !flush) |=> $stable(cnt));
        // R7: flush empties in one cycle and clears overflow
        p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> (cnt == '0 && !ovf));
        // R10: no interrupt without its enable
        p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en |-> !irq);
    end

endmodule

// File: rtl/ep_sel_mux.sv
// Module: ep_sel_mux
// Selects one of N equal-width lanes by index. An index with no lane behind
// it returns zero. Assumes the lanes arrive as a packed array.
module ep_sel_mux #(
    parameter int unsigned N  = 4,
    parameter int unsigned W  = 8,
    parameter int unsigned SW = 2
) (
    input  logic [N-1:0][W-1:0] lanes,
    input  logic [SW-1:0]       sel,
    output logic [W-1:0]        dout
);

    // Pick the addressed lane, guarding indices past the last lane.
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == SW'(i)) dout = lanes[i];
        end
    end

endmodule

// File: rtl/txfifo_bank.sv
// Module: txfifo_bank
// A bank of NUM_EP transmit FIFOs, one per IN endpoint, each sized by
// DEPTHS. It decodes the shared word write port and the drain port onto
// the endpoints and multiplexes the drain data and the status read back out.
// Assumes one write and one read per cycle at most.
module txfifo_bank
    import txfb_pkg::*;
#(
    parameter int unsigned NUM_EP         = 4,
    parameter int unsigned DW             = 32,
    parameter int unsigned DEPTHS [NUM_EP] = '{64, 128, 0, 0},
    localparam int unsigned EPW           = (NUM_EP <= 2) ? 1 : $clog2(NUM_EP),
    localparam int unsigned CW            = cnt_width(max_depth())
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_mode,
    input  logic [NUM_EP-1:0] irq_en,
    input  logic [NUM_EP-1:0] flush,
    input  logic              wr_en,
    input  logic [EPW-1:0]    wr_ep,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [EPW-1:0]    rd_ep,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    input  logic [EPW-1:0]    stat_ep,
    output logic [CW-1:0]     stat_free,
    output logic [NUM_EP-1:0] irq,
    output logic [NUM_EP-1:0] ovf
);

    // Largest configured depth, used to size the free-space count.
    function automatic int unsigned max_depth();
        int unsigned m = 0;
        for (int i = 0; i < NUM_EP; i++) if (DEPTHS[i] > m) m = DEPTHS[i];
        return m;
    endfunction

    logic [NUM_EP-1:0][DW-1:0] head_data;
    logic [NUM_EP-1:0][CW-1:0] free_cnt;
    logic [NUM_EP-1:0][0:0]    head_valid;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic push_req, pop_req;

        // Decode the shared ports onto this endpoint.
        assign push_req = wr_en && (wr_ep == EPW'(g));
        assign pop_req  = rd_en && (rd_ep == EPW'(g));

        ep_fifo #(.DEPTH(DEPTHS[g]), .DW(DW), .CW(CW)) i_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .half_mode  (half_mode),
            .irq_en     (irq_en[g]),
            .flush      (flush[g]),
            .push_req   (push_req),
            .pop_req    (pop_req),
            .push_data  (wr_data),
            .head_data  (head_data[g]),
            .head_valid (head_valid[g][0]),
            .free_cnt   (free_cnt[g]),
            .irq        (irq[g]),
            .ovf        (ovf[g])
        );
    end

    ep_sel_mux #(.N(NUM_EP), .W(DW), .SW(EPW)) i_rd_mux (
        .lanes (head_data),
        .sel   (rd_ep),
        .dout  (rd_data)
    );

    ep_sel_mux #(.N(NUM_EP), .W(1), .SW(EPW)) i_vld_mux (
        .lanes (head_valid),
        .sel   (rd_ep),
        .dout  (rd_valid)
    );

    ep_sel_mux #(.N(NUM_EP), .W(CW), .SW(EPW)) i_stat_mux (
        .lanes (free_cnt),
        .sel   (stat_ep),
        .dout  (stat_free)
    );

    // R4: valid data is never offered by an endpoint whose free count is its full depth
    p_valid_vs_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ep == stat_ep && stat_free == CW'(max_depth()) && max_depth() != 0
         && DEPTHS[rd_ep] == max_depth()) |-> !rd_valid);

endmodule

// File: tb/test_txfifo_bank.sv
// Bench: test_txfifo_bank
// Sweeps a small configuration (depths 4, 5, 0, 2) through fill, overfill,
// drain, pass-through and flush in both threshold modes, against an
// arithmetic ring-buffer model kept in the bench.
module test_txfifo_bank;

    localparam int unsigned DEP [4] = '{4, 5, 0, 2};
    localparam int CW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_mode = 1'b0;
    logic [3:0]  irq_en = 4'hF;
    logic [3:0]  flush = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ep = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_ep = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [1:0]  stat_ep = '0;
    logic [CW-1:0] stat_free;
    logic [3:0]  irq, ovf;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    int          mcnt [4];
    int          mhead [4];
    logic [31:0] mdat [4][8];
    bit          movf [4];

    txfifo_bank #(.NUM_EP(4), .DW(32), .DEPTHS('{4, 5, 0, 2})) i_txfifo_bank (
        .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .irq_en(irq_en),
        .flush(flush), .wr_en(wr_en), .wr_ep(wr_ep), .wr_data(wr_data),
        .rd_en(rd_en), .rd_ep(rd_ep), .rd_data(rd_data), .rd_valid(rd_valid),
        .stat_ep(stat_ep), .stat_free(stat_free), .irq(irq), .ovf(ovf)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_irq(input int e);
        if (DEP[e] == 0 || !irq_en[e]) return 1'b0;
        if (half_mode) return (2 * (DEP[e] - mcnt[e])) >= DEP[e];
        return mcnt[e] == 0;
    endfunction

    // Compare every endpoint's status, interrupt and overflow with the model.
    task automatic check_all();
        for (int e = 0; e < 4; e++) begin
            stat_ep = 2'(e);
            #1;
            if (DEP[e] == 0) chk(stat_free == 0, "R11 free", stat_free, 0);
            else chk(int'(stat_free) == DEP[e] - mcnt[e], "R2/R12 free", stat_free, DEP[e] - mcnt[e]);
            if (half_mode) chk(irq[e] == exp_irq(e), "R9 irq", irq[e], exp_irq(e));
            else           chk(irq[e] == exp_irq(e), "R8 irq", irq[e], exp_irq(e));
            chk(ovf[e] == movf[e], "R3 ovf", ovf[e], movf[e]);
        end
    endtask

    // One clock of stimulus: inputs set at the falling edge, the head checked
    // before the rising edge, the model updated at it, status checked after.
    task automatic step(input bit wen, input int wep, input logic [31:0] wdat,
                        input bit ren, input int rep, input logic [3:0] fl);
        wr_en = wen; wr_ep = 2'(wep); wr_data = wdat;
        rd_en = ren; rd_ep = 2'(rep); flush = fl;
        #1;
        if (mcnt[rep] == 0) chk(rd_valid == 1'b0, "R5 valid", rd_valid, 0);
        else begin
            chk(rd_valid == 1'b1, "R4 valid", rd_valid, 1);
            chk(rd_data == mdat[rep][mhead[rep]], "R4 order", rd_data, mdat[rep][mhead[rep]]);
        end
        @(posedge clk);
        for (int e = 0; e < 4; e++) begin
            if (fl[e]) begin
                mcnt[e] = 0; mhead[e] = 0; movf[e] = 0;
            end else begin
                bit pop = ren && rep == e && mcnt[e] > 0;
                bit psh = wen && wep == e;
                if (psh && mcnt[e] == DEP[e]) begin
                    movf[e] = 1;
                    psh = 0;
                end
                if (psh) mdat[e][(mhead[e] + mcnt[e]) % DEP[e]] = wdat;
                if (pop) mhead[e] = (mhead[e] + 1) % DEP[e];
                mcnt[e] = mcnt[e] + int'(psh) - int'(pop);
            end
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; flush = '0;
        check_all();
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int e = 0; e < 4; e++) begin
            mcnt[e] = 0; mhead[e] = 0; movf[e] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, checked with the interrupts in the fully-empty mode
        check_all();
        for (int e = 0; e < 4; e++) begin
            rd_ep = 2'(e);
            #1;
            chk(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
        end

        for (int m = 0; m < 2; m++) begin
            half_mode = m[0];
            step(0, 0, 0, 0, 0, 4'hF);
            for (int e = 0; e < 4; e++) begin
                // R2/R3/R11: fill past the depth, one word per cycle
                for (int k = 0; k <= DEP[e]; k++)
                    step(1, e, {8'(e), 8'(m), 16'(k) ^ 16'hA5C3}, 0, 0, 4'h0);
                // R3: the overflow flag stays set through later reads
                // R4/R5: drain one beyond empty
                for (int k = 0; k <= DEP[e]; k++)
                    step(0, 0, 0, 1, e, 4'h0);
                // R6: write and read together on a partly filled FIFO
                if (DEP[e] >= 2) begin
                    step(1, e, 32'h1111_0000 + e, 0, e, 4'h0);
                    for (int k = 0; k < 3; k++)
                        step(1, e, 32'h2222_0000 + k, 1, e, 4'h0);
                end
                // R7: fill other endpoints a little, then flush this one only
                step(1, (e + 1) % 4, 32'hBEEF_0000 + e, 0, 0, 4'h0);
                step(1, e, 32'hCAFE_0000 + e, 0, e, 4'h0);
                step(0, 0, 0, 0, e, 4'(1 << e));
                step(0, 0, 0, 0, (e + 1) % 4, 4'(1 << ((e + 1) % 4)));
            end
            // R10: every enable pattern with endpoint 0 empty, endpoint 1 partly full
            step(1, 1, 32'h0000_00F1, 0, 0, 4'h0);
            for (int p = 0; p < 16; p++) begin
                irq_en = 4'(p);
                #1;
                for (int e = 0; e < 4; e++)
                    chk(irq[e] == exp_irq(e), "R10 gate", irq[e], exp_irq(e));
            end
            irq_en = 4'hF;
            // R9: walk endpoint 1 (depth 5) through every level in this mode
            for (int k = 0; k < 5; k++) step(1, 1, 32'h0000_0100 + k, 0, 0, 4'h0);
            for (int k = 0; k < 5; k++) step(0, 0, 0, 1, 1, 4'h0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule